// File: doc/BRIEF.md
# Doubleword Load/Store Timing Sequencer

This block sets the cycle-accurate timing of an instruction that loads or stores a register pair with one address. A decoded request carries the direction (load or store), the indexing form (pre or post), the offset kind (immediate or register), the offset sign, a writeback flag, the already computed address and, for stores, the two source words. The sequencer first decides how many issue cycles the form costs. It holds the pipeline front end with an issue-stall signal for the extra cycles. It then emits either one doubleword memory beat or two word beats. For loads it pulses a ready strobe for each destination register, and it pulses a strobe for the updated base register whenever writeback is requested.

The issue cost depends only on the addressing form. A pre-indexed access with a subtracted register offset costs three issue cycles by default. Every other form costs one. Alignment decides the beat count. It has no effect on issue length or on base-register timing, but it delays the second loaded register by one cycle. A request is taken only when the block is idle and the front end reports that the base and offset registers are available. While they are not, the block raises the stall. A new request may be accepted as soon as the previous operation's memory beats are done. Result strobes still in flight from that operation keep running alongside the new one.

Top module: `lsd_seq`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid`, `opnd_ready` and `req_ready` are all high. `req_ready` is high whenever no operation holds the block.
- R2: While `req_valid` and `req_ready` are high and `opnd_ready` is low, `issue_stall` is high in the same cycle and nothing is accepted: no beat and no strobe follows.
- R3: Let cycle 1 be the first cycle after the accepting edge. The issue length N is SLOW_ISSUE (default 3) when `req_pre`, `req_reg_off` and `req_sub` are all 1, and 1 otherwise. `issue_stall` is high in cycles 1 to N-1 and low afterwards.
- R4: The occupancy O is N+1 when the address is misaligned or `req_wb` is 1, and N otherwise. `req_ready` is low in cycles 1 to O-1 and high again in cycle O.
- R5: An address with bits [2:0] equal to zero gives one beat, in cycle N. That beat has `mem_dbl`=1, `mem_addr` equal to the request address and, for a store, `mem_wdata` = {src_hi, src_lo}.
- R6: A misaligned address gives two word beats with `mem_dbl`=0. The first is in cycle N at the request address with store data {0, src_lo}. The second is in cycle N+1 at the address plus 4 with store data {0, src_hi}.
- R7: For a load, `rd_lo_valid` pulses in cycle N+1. `rd_hi_valid` pulses in cycle N+1 when the address is aligned and in cycle N+2 when it is misaligned.
- R8: `base_valid` pulses in cycle N+1 exactly when `req_wb` is 1, for loads and stores alike and regardless of alignment.
- R9: A store drives `mem_write`=1 on its beats and raises neither `rd_lo_valid` nor `rd_hi_valid`. A load drives `mem_write`=0 and `mem_wdata`=0 on its beats.
- R10: After reset `req_ready` is 1 and `issue_stall`, `mem_valid` and every strobe are 0.
- R11: A request accepted in cycle O of the previous operation proceeds with its own timing. Strobes still pending from the previous operation, such as a misaligned load's second register, still arrive in their own cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Block can take a request |
| opnd_ready | input | 1 | Base and offset registers available |
| req_load | input | 1 | 1 = load pair, 0 = store pair |
| req_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| req_reg_off | input | 1 | 1 = register offset, 0 = immediate |
| req_sub | input | 1 | 1 = offset subtracted |
| req_wb | input | 1 | Base writeback requested |
| req_addr | input | ADDR_W | Computed access address |
| req_src_lo | input | DATA_W | Store data, first register |
| req_src_hi | input | DATA_W | Store data, second register |
| issue_stall | output | 1 | Hold the pipeline front end |
| mem_valid | output | 1 | Memory beat present |
| mem_write | output | 1 | Beat is a write |
| mem_dbl | output | 1 | Beat is a full doubleword |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | 2*DATA_W | Beat write data |
| rd_lo_valid | output | 1 | First loaded register ready |
| rd_hi_valid | output | 1 | Second loaded register ready |
| base_valid | output | 1 | Updated base register ready |

## Verification
Two functions can land in the same cycle. One is the late second-register strobe of a misaligned one-issue load. The other is the issue stall of a three-issue request accepted the moment `req_ready` returns. The bench provokes this by queuing the slow store while the load's second beat is still out. In the cycle after acceptance it requires both `rd_hi_valid` and `issue_stall` to be high. It then requires the store's beat and its base strobe in their own cycles, with no stray data strobe.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef struct packed {
    logic load;
    logic pre;
    logic reg_off;
    logic sub;
    logic wb;
  } lsd_mode_t;

  // Pre-indexed with a subtracted register offset is the only slow form.
  function automatic logic lsd_is_slow(lsd_mode_t m);
    return m.pre & m.reg_off & m.sub;
  endfunction

  function automatic logic lsd_misaligned(logic [2:0] low_bits);
    return |low_bits;
  endfunction

  localparam int unsigned LSD_NUM_STROBES = 3;
  localparam int unsigned LSD_STB_LO      = 0;
  localparam int unsigned LSD_STB_HI      = 1;
  localparam int unsigned LSD_STB_BASE    = 2;

endpackage

// File: rtl/lsd_issue_ctrl.sv
module lsd_issue_ctrl #(
  parameter int unsigned SLOW_ISSUE = 3,
  localparam int unsigned CNT_W     = $clog2(SLOW_ISSUE + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic opnd_ready,
  input  logic slow,
  input  logic tail,
  output logic req_ready,
  output logic accept,
  output logic issue_stall
);

  logic [CNT_W-1:0] stall_q, stall_d;
  logic [CNT_W-1:0] busy_q, busy_d;
  logic [CNT_W-1:0] extra_issue;
  logic             cnt_en;

  assign req_ready   = (busy_q == '0);
  assign accept      = req_valid & opnd_ready & req_ready;
  assign extra_issue = slow ? CNT_W'(SLOW_ISSUE - 1) : '0;
  assign issue_stall = (stall_q != '0) | (req_valid & ~opnd_ready & req_ready);
  assign cnt_en      = accept | (busy_q != '0);

  always_comb begin
    stall_d = stall_q;
    busy_d  = busy_q;
    if (accept) begin
      stall_d = extra_issue;
      busy_d  = extra_issue + CNT_W'(tail);
    end else begin
      if (stall_q != '0) stall_d = stall_q - 1'b1;
      if (busy_q  != '0) busy_d  = busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= '0;
      busy_q  <= '0;
    end else if (cnt_en) begin
      stall_q <= stall_d;
      busy_q  <= busy_d;
    end
  end

  AST_STALL_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q != '0) |-> !req_ready);  // R4

  AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q != '0) |=> (stall_q == $past(stall_q) - 1'b1));  // R3

  AST_HAZARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !opnd_ready) |-> !accept);  // R2

endmodule

// File: rtl/lsd_beat_gen.sv
module lsd_beat_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SLOW_ISSUE = 3,
  localparam int unsigned LINE_W    = SLOW_ISSUE + 2,
  localparam int unsigned IDX_W     = $clog2(LINE_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  slow,
  input  logic                  misal,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     src_lo,
  input  logic [DATA_W-1:0]     src_hi,
  output logic                  mem_valid,
  output logic                  mem_write,
  output logic                  mem_dbl,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*DATA_W-1:0]   mem_wdata
);

  logic [LINE_W-1:0] first_q, first_d, second_q, second_d;
  logic [LINE_W-1:0] first_mask, second_mask;
  logic [IDX_W-1:0]  first_idx;
  logic              line_en;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic              write_q, dbl_q;

  assign first_idx   = slow ? IDX_W'(SLOW_ISSUE - 1) : '0;
  assign first_mask  = LINE_W'(1) << first_idx;
  assign second_mask = misal ? (first_mask << 1) : '0;
  assign line_en     = accept | (|first_q) | (|second_q);

  always_comb begin
    first_d  = first_q >> 1;
    second_d = second_q >> 1;
    if (accept) begin
      first_d  = first_d | first_mask;
      second_d = second_d | second_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
    end else if (line_en) begin
      first_q  <= first_d;
      second_q <= second_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      write_q <= 1'b0;
      dbl_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr;
      lo_q    <= src_lo;
      hi_q    <= src_hi;
      write_q <= ~load;
      dbl_q   <= ~misal;
    end
  end

  assign mem_valid = first_q[0] | second_q[0];
  assign mem_write = mem_valid & write_q;
  assign mem_dbl   = first_q[0] & dbl_q;
  assign mem_addr  = second_q[0] ? (addr_q + ADDR_W'(4)) : addr_q;

  always_comb begin
    mem_wdata = '0;
    if (write_q) begin
      if (first_q[0] && dbl_q)  mem_wdata = {hi_q, lo_q};
      else if (first_q[0])      mem_wdata = {{DATA_W{1'b0}}, lo_q};
      else if (second_q[0])     mem_wdata = {{DATA_W{1'b0}}, hi_q};
    end
  end

  AST_DBL_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_dbl) |-> (mem_addr[2:0] == 3'b000));  // R5

  AST_SECOND_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    second_q[0] |-> ($past(first_q[0]) && mem_addr == $past(mem_addr) + ADDR_W'(4)));  // R6

  AST_ONE_BEAT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(first_q[0] && second_q[0]));  // R6

endmodule

// File: rtl/lsd_strobe_sched.sv
module lsd_strobe_sched
  import lsd_pkg::*;
#(
  parameter int unsigned SLOW_ISSUE = 3,
  localparam int unsigned LINE_W    = SLOW_ISSUE + 2,
  localparam int unsigned IDX_W     = $clog2(LINE_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       slow,
  input  logic                       misal,
  input  logic                       load,
  input  logic                       wb,
  output logic [LSD_NUM_STROBES-1:0] strobe
);

  logic [IDX_W-1:0]  lat_idx;
  logic [IDX_W-1:0]  hi_idx;
  logic [LINE_W-1:0] lat_mask, hi_mask;
  logic [LSD_NUM_STROBES-1:0][LINE_W-1:0] sched_mask;

  assign lat_idx  = slow ? IDX_W'(SLOW_ISSUE) : IDX_W'(1);
  assign hi_idx   = lat_idx + IDX_W'(misal);
  assign lat_mask = LINE_W'(1) << lat_idx;
  assign hi_mask  = LINE_W'(1) << hi_idx;

  always_comb begin
    sched_mask               = '0;
    sched_mask[LSD_STB_LO]   = load ? lat_mask : '0;
    sched_mask[LSD_STB_HI]   = load ? hi_mask  : '0;
    sched_mask[LSD_STB_BASE] = wb   ? lat_mask : '0;
  end

  for (genvar g = 0; g < LSD_NUM_STROBES; g++) begin : g_line
    logic [LINE_W-1:0] line_q, line_d;
    logic              line_en;

    assign line_en = accept | (|line_q);

    always_comb begin
      line_d = line_q >> 1;
      if (accept) line_d = line_d | sched_mask[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       line_q <= '0;
      else if (line_en) line_q <= line_d;
    end

    assign strobe[g] = line_q[0];
  end

  AST_HI_TRAILS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[LSD_STB_HI] |-> (strobe[LSD_STB_LO] || $past(strobe[LSD_STB_LO])));  // R7

endmodule

// File: rtl/lsd_seq.sv
module lsd_seq
  import lsd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SLOW_ISSUE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                opnd_ready,
  input  logic                req_load,
  input  logic                req_pre,
  input  logic                req_reg_off,
  input  logic                req_sub,
  input  logic                req_wb,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_src_lo,
  input  logic [DATA_W-1:0]   req_src_hi,
  output logic                issue_stall,
  output logic                mem_valid,
  output logic                mem_write,
  output logic                mem_dbl,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] mem_wdata,
  output logic                rd_lo_valid,
  output logic                rd_hi_valid,
  output logic                base_valid
);

  lsd_mode_t                  mode;
  logic                       slow, misal, tail, accept;
  logic [LSD_NUM_STROBES-1:0] strobe;

  assign mode  = '{load: req_load, pre: req_pre, reg_off: req_reg_off,
                   sub: req_sub, wb: req_wb};
  assign slow  = lsd_is_slow(mode);
  assign misal = lsd_misaligned(req_addr[2:0]);
  assign tail  = misal | req_wb;

  lsd_issue_ctrl #(.SLOW_ISSUE(SLOW_ISSUE)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .opnd_ready  (opnd_ready),
    .slow        (slow),
    .tail        (tail),
    .req_ready   (req_ready),
    .accept      (accept),
    .issue_stall (issue_stall)
  );

  lsd_beat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOW_ISSUE(SLOW_ISSUE)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .slow      (slow),
    .misal     (misal),
    .load      (req_load),
    .addr      (req_addr),
    .src_lo    (req_src_lo),
    .src_hi    (req_src_hi),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_dbl   (mem_dbl),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  lsd_strobe_sched #(.SLOW_ISSUE(SLOW_ISSUE)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .slow   (slow),
    .misal  (misal),
    .load   (req_load),
    .wb     (req_wb),
    .strobe (strobe)
  );

  assign rd_lo_valid = strobe[LSD_STB_LO];
  assign rd_hi_valid = strobe[LSD_STB_HI];
  assign base_valid  = strobe[LSD_STB_BASE];

  initial begin
    AST_SLOW_ISSUE_RANGE: assert (SLOW_ISSUE >= 2);  // R3
  end

  AST_LOAD_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write) |-> (mem_wdata == '0));  // R9

  AST_BEAT_NOT_DURING_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !opnd_ready && req_ready) |=> !mem_valid);  // R2

endmodule

// File: tb/sim_lsd_seq.sv
module sim_lsd_seq;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SLOW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, opnd_ready = 1'b1;
  logic          req_load = 1'b0, req_pre = 1'b0, req_reg_off = 1'b0;
  logic          req_sub = 1'b0, req_wb = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_src_lo = '0, req_src_hi = '0;
  logic          req_ready, issue_stall, mem_valid, mem_write, mem_dbl;
  logic [AW-1:0] mem_addr;
  logic [2*DW-1:0] mem_wdata;
  logic          rd_lo_valid, rd_hi_valid, base_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  lsd_seq #(.ADDR_W(AW), .DATA_W(DW), .SLOW_ISSUE(SLOW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .opnd_ready(opnd_ready), .req_load(req_load), .req_pre(req_pre),
    .req_reg_off(req_reg_off), .req_sub(req_sub), .req_wb(req_wb),
    .req_addr(req_addr), .req_src_lo(req_src_lo), .req_src_hi(req_src_hi),
    .issue_stall(issue_stall), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_dbl(mem_dbl), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_lo_valid(rd_lo_valid), .rd_hi_valid(rd_hi_valid), .base_valid(base_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic ld, pre, rg, sub, wb, input logic [AW-1:0] a);
    req_load = ld; req_pre = pre; req_reg_off = rg; req_sub = sub; req_wb = wb;
    req_addr = a; req_src_lo = 32'h1100_0000 ^ a; req_src_hi = 32'h2200_0000 ^ a;
    req_valid = 1'b1;
  endtask

  // R10: reset state
  task automatic t_reset;
    @(negedge clk);
    chk("R10 ready", {63'd0, req_ready}, 64'd1);
    chk("R10 stall", {63'd0, issue_stall}, 64'd0);
    chk("R10 mem_valid", {63'd0, mem_valid}, 64'd0);
    chk("R10 strobes", {61'd0, rd_lo_valid, rd_hi_valid, base_valid}, 64'd0);
  endtask

  // R1, R3 to R9: one operation, every cycle checked against the derived timing
  task automatic t_op(input logic ld, pre, rg, sub, wb, input logic [AW-1:0] a);
    int n, occ;
    logic mis;
    logic [DW-1:0] lo, hi;
    mis = (a[2:0] != 3'b000);
    n   = (pre && rg && sub) ? SLOW : 1;
    occ = (mis || wb) ? n + 1 : n;
    @(negedge clk);
    drive(ld, pre, rg, sub, wb, a);
    lo = req_src_lo; hi = req_src_hi;
    chk("R1 ready before accept", {63'd0, req_ready}, 64'd1);
    @(posedge clk);
    #2 req_valid = 1'b0;
    for (int t = 1; t <= 7; t++) begin
      @(negedge clk);
      chk("R3 issue_stall", {63'd0, issue_stall}, {63'd0, (t <= n - 1)});
      chk("R4 req_ready", {63'd0, req_ready}, {63'd0, !(t <= occ - 1)});
      chk(mis ? "R6 mem_valid" : "R5 mem_valid", {63'd0, mem_valid},
          {63'd0, (t == n) || (mis && t == n + 1)});
      if (t == n) begin
        chk(mis ? "R6 dbl" : "R5 dbl", {63'd0, mem_dbl}, {63'd0, !mis});
        chk(mis ? "R6 addr1" : "R5 addr", {32'd0, mem_addr}, {32'd0, a});
        chk("R9 write", {63'd0, mem_write}, {63'd0, !ld});
        chk(mis ? "R6 wdata1" : "R5 wdata", mem_wdata,
            ld ? 64'd0 : (mis ? {32'd0, lo} : {hi, lo}));
      end
      if (mis && t == n + 1) begin
        chk("R6 dbl2", {63'd0, mem_dbl}, 64'd0);
        chk("R6 addr2", {32'd0, mem_addr}, {32'd0, a + 32'd4});
        chk("R6 wdata2", mem_wdata, ld ? 64'd0 : {32'd0, hi});
      end
      chk(ld ? "R7 rd_lo" : "R9 rd_lo", {63'd0, rd_lo_valid}, {63'd0, ld && t == n + 1});
      chk(ld ? "R7 rd_hi" : "R9 rd_hi", {63'd0, rd_hi_valid},
          {63'd0, ld && (t == n + 1 + (mis ? 1 : 0))});
      chk("R8 base", {63'd0, base_valid}, {63'd0, wb && t == n + 1});
    end
  endtask

  // R2: operand hazard holds the request
  task automatic t_hazard;
    @(negedge clk);
    opnd_ready = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_4000);
    #1;
    chk("R2 stall on hazard", {63'd0, issue_stall}, 64'd1);
    chk("R2 ready on hazard", {63'd0, req_ready}, 64'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 no beat", {63'd0, mem_valid}, 64'd0);
      chk("R2 no strobe", {63'd0, rd_lo_valid}, 64'd0);
      chk("R2 still stalled", {63'd0, issue_stall}, 64'd1);
    end
    opnd_ready = 1'b1;
    @(posedge clk);
    #2 req_valid = 1'b0;
    @(negedge clk);
    chk("R2 beat after release", {63'd0, mem_valid}, 64'd1);
    @(negedge clk);
    chk("R2 lo after release", {63'd0, rd_lo_valid}, 64'd1);
    repeat (4) @(negedge clk);
  endtask

  // R11: slow store accepted while a misaligned load's hi strobe is pending
  task automatic t_overlap;
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_2004);
    @(posedge clk);
    #2 req_valid = 1'b0;
    @(negedge clk);  // cycle 1
    chk("R11 busy c1", {63'd0, req_ready}, 64'd0);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_3000);
    @(negedge clk);  // cycle 2
    chk("R11 ready c2", {63'd0, req_ready}, 64'd1);
    chk("R11 beat2 addr", {32'd0, mem_addr}, 64'h2008);
    chk("R11 lo c2", {63'd0, rd_lo_valid}, 64'd1);
    @(posedge clk);
    #2 req_valid = 1'b0;
    @(negedge clk);  // cycle 3 = store cycle 1
    chk("R11 old hi strobe", {63'd0, rd_hi_valid}, 64'd1);
    chk("R11 new stall", {63'd0, issue_stall}, 64'd1);
    @(negedge clk);  // cycle 4
    chk("R11 stall c4", {63'd0, issue_stall}, 64'd1);
    chk("R11 no beat c4", {63'd0, mem_valid}, 64'd0);
    @(negedge clk);  // cycle 5 = store cycle 3
    chk("R11 store beat", {62'd0, mem_valid, mem_dbl}, 64'd3);
    chk("R11 store write", {63'd0, mem_write}, 64'd1);
    chk("R11 store addr", {32'd0, mem_addr}, 64'h3000);
    chk("R11 stall off", {63'd0, issue_stall}, 64'd0);
    @(negedge clk);  // cycle 6 = store cycle 4
    chk("R11 store base", {63'd0, base_valid}, 64'd1);
    chk("R11 no data strobe", {62'd0, rd_lo_valid, rd_hi_valid}, 64'd0);
    chk("R11 ready c6", {63'd0, req_ready}, 64'd1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_sweep;
    int k = 0;
    for (int ld = 0; ld < 2; ld++)
      for (int f = 0; f < 8; f++)
        for (int wb = 0; wb < 2; wb++)
          for (int m = 0; m < 2; m++) begin
            logic [AW-1:0] a;
            a = 32'h0001_0000 + 32'(k * 16);
            if (m == 1) a = a + ((k % 2) ? 32'd4 : 32'd2);
            t_op(ld[0], f[2], f[1], f[0], wb[0], a);
            k++;
          end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_sweep();
    t_hazard();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule